// File: doc/BRIEF.md
# Linked Wait-Queue Manager

This block keeps the lists of threads that are blocked on synchronization objects. Each list is a doubly-linked chain of 64-bit entries in a private single-port scratchpad. Every list draws its entries from one shared pool, and a list uses storage only while threads are actually waiting on it. The block stores no list headers. The synchronization engine keeps a (head, tail) pointer pair for each object, hands that pair in with every command, and stores the updated pair that comes back.

Three commands are supported: clear a pair, append a thread at the tail, and remove the thread at the head. The block runs the scratchpad reads and writes for each command one at a time. The memory returns read data two cycles after the request. An allocator hands out entries: released entries are reused first, and untouched entries are handed out next. Each entry word holds, from bit 0 upward, an in-use flag, a 15-bit previous pointer, a reserved bit at position 16, a 15-bit next pointer and a 32-bit thread word. The thread word is a zero byte, then an 8-bit processor number, then a 16-bit thread number.

Commands and responses both use valid/ready. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low from that edge until the response has been taken, so only one command is in flight at a time. The response is held unchanged while `rsp_valid` is high and `rsp_ready` is low. It leaves on the first edge where both are high.

Top module: `wq_manager`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `rsp_valid` is 0. While the release list is empty, enqueues take pool entries in ascending order starting at entry 0.
- R2: Only one command is in flight. `cmd_ready` is low from the accepting edge until the response handshake. While `rsp_valid` is 1 and `rsp_ready` is 0, every response field holds its value.
- R3: Op code 0 (and the spare code 3) returns head = tail = nil (0x7FFF) with both flags clear.
- R4: Enqueue (op 1) onto a queue whose head is nil returns head = tail = the new entry. Onto a non-empty queue it returns the input head unchanged and tail = the new entry.
- R5: Dequeue (op 2) returns the processor and thread numbers of the head entry, and the old head's successor as the new head. Threads leave a queue in the order they arrived.
- R6: A dequeue that removes the only element returns head = tail = nil.
- R7: A dequeue with head = nil returns the empty flag, head = tail = nil and thread fields of 0. It makes no memory access and responds one cycle after acceptance.
- R8: A released entry goes onto a release list. An enqueue takes the most recently released entry before any untouched one.
- R9: When every pool entry is in use, an enqueue returns the full flag and echoes the input head and tail. No entry is consumed, so the next release and enqueue behave as if that request never happened.
- R10: `rsp_valid` rises in cycle K+1 after the accepting edge. For an enqueue, K = 1, plus 2 when a released entry is reused, plus 3 when the input tail is not nil. For a non-empty dequeue, K = 3, plus 3 when the head had a successor. K = 0 for clear, empty dequeue and full enqueue.
- R11: Several queues share the pool. Interleaved enqueues to different queues keep each queue's links and order separate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_op | input | 2 | 0 clear, 1 enqueue, 2 dequeue, 3 treated as clear |
| cmd_head | input | 15 | Queue head pointer, 0x7FFF = nil |
| cmd_tail | input | 15 | Queue tail pointer, 0x7FFF = nil |
| cmd_cpu | input | 8 | Processor number of the waiting thread (enqueue) |
| cmd_thr | input | 16 | Thread number of the waiting thread (enqueue) |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_head | output | 15 | Updated head pointer |
| rsp_tail | output | 15 | Updated tail pointer |
| rsp_cpu | output | 8 | Processor number of the dequeued thread, otherwise 0 |
| rsp_thr | output | 16 | Thread number of the dequeued thread, otherwise 0 |
| rsp_empty | output | 1 | Dequeue found the queue empty |
| rsp_full | output | 1 | Enqueue found no free entry |

## Verification
The bench targets the corner cases below and what a faulty design would do in each:

- **Removing the sole element.** A design that cleared only the head would hand back a stale tail, and the next append would link onto a released entry.
- **Reuse order.** A design that preferred untouched entries, or reused in FIFO rather than LIFO order, would give pointers that differ from the model on the first enqueue after a release.
- **Enqueue into a full pool.** The bench fills the pool and requests once more. A design that advanced its counter or pointer anyway would leak an entry and report full one enqueue too early later.
- **Back-pressure and timing.** Stalled responses and the per-command latency are compared on every clock. A missing wait state or a dropped link-update step therefore shows up as a shifted `rsp_valid`.

// File: rtl/wq_pkg.sv
package wq_pkg;
  localparam int PTR_W = 15;
  typedef logic [PTR_W-1:0] ptr_t;
  localparam ptr_t NIL = '1;

  typedef enum logic [1:0] {
    OP_CLR = 2'd0,
    OP_ENQ = 2'd1,
    OP_DEQ = 2'd2,
    OP_SPR = 2'd3
  } op_e;

  // 32-bit thread word: zero pad, processor, thread
  typedef struct packed {
    logic [7:0]  pad;
    logic [7:0]  cpu;
    logic [15:0] thr;
  } tid_t;

  // 64-bit entry, bit 0 is the in-use flag, bit 16 reserved
  typedef struct packed {
    tid_t tid;
    ptr_t nxt;
    logic rsv;
    ptr_t prv;
    logic used;
  } entry_t;
endpackage

// File: rtl/wq_spram.sv
module wq_spram
  import wq_pkg::*;
#(
  parameter int DEPTH = 122,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  entry_t        wdata,
  output entry_t        rdata
);
  entry_t mem [DEPTH];
  entry_t stage1, stage2;

  // two-stage read path: data visible two cycles after the request
  always_ff @(posedge clk) begin
    if (en && we) mem[addr] <= wdata;
    if (en && !we) stage1 <= mem[addr];
    stage2 <= stage1;
  end

  assign rdata = stage2;

  // a read request is always followed by an idle port cycle (wait state)
  assert_read_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !we) |=> !en);

  // only pool entries are ever addressed
  assert_addr_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (int'(addr) < DEPTH));
endmodule

// File: rtl/wq_alloc.sv
module wq_alloc
  import wq_pkg::*;
#(
  parameter int N = 122,
  localparam int CW = $clog2(N + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take_fresh,
  input  logic head_we,
  input  ptr_t head_d,
  output ptr_t free_head,
  output ptr_t fresh_ptr,
  output logic avail
);
  logic [CW-1:0] fresh_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      free_head <= NIL;
      fresh_cnt <= '0;
    end else begin
      if (head_we) free_head <= head_d;
      if (take_fresh) fresh_cnt <= fresh_cnt + 1'b1;
    end
  end

  assign fresh_ptr = ptr_t'(fresh_cnt);
  assign avail     = (free_head != NIL) || (fresh_cnt != CW'(N));

  // never hand out more untouched entries than the pool holds
  assert_fresh_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fresh_cnt <= CW'(N));

  // an untouched entry is taken only when the release list is empty
  assert_reuse_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take_fresh |-> (free_head == NIL));

  // release-list head and counter are never moved by the same step
  assert_single_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(take_fresh && head_we));
endmodule

// File: rtl/wq_seq.sv
module wq_seq
  import wq_pkg::*;
#(
  parameter int N = 122,
  localparam int AW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  ptr_t          cmd_head,
  input  ptr_t          cmd_tail,
  input  logic [7:0]    cmd_cpu,
  input  logic [15:0]   cmd_thr,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output ptr_t          rsp_head,
  output ptr_t          rsp_tail,
  output logic [7:0]    rsp_cpu,
  output logic [15:0]   rsp_thr,
  output logic          rsp_empty,
  output logic          rsp_full,
  input  ptr_t          free_head,
  input  ptr_t          fresh_ptr,
  input  logic          avail,
  output logic          take_fresh,
  output logic          head_we,
  output ptr_t          head_d,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output entry_t        mem_wdata,
  input  entry_t        mem_rdata
);
  typedef enum logic [3:0] {
    S_IDLE, S_EFRD, S_EFWT, S_ENEW, S_ETRD, S_ETWT, S_ETWR,
    S_DHRD, S_DHWT, S_DHWR, S_DNRD, S_DNWT, S_DNWR, S_RESP
  } st_e;

  st_e   st;
  ptr_t  c_head, c_tail, new_ptr, nxt_sv;
  tid_t  c_tid;
  logic  popped;
  ptr_t  r_head, r_tail;
  logic [7:0]  r_cpu;
  logic [15:0] r_thr;
  logic  r_empty, r_full;
  op_e   op;
  logic  fire;

  assign op        = op_e'(cmd_op);
  assign cmd_ready = (st == S_IDLE);
  assign rsp_valid = (st == S_RESP);
  assign fire      = cmd_valid && cmd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      c_head  <= NIL;
      c_tail  <= NIL;
      c_tid   <= '0;
      new_ptr <= NIL;
      nxt_sv  <= NIL;
      popped  <= 1'b0;
      r_head  <= NIL;
      r_tail  <= NIL;
      r_cpu   <= '0;
      r_thr   <= '0;
      r_empty <= 1'b0;
      r_full  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (cmd_valid) begin
          c_head  <= cmd_head;
          c_tail  <= cmd_tail;
          c_tid   <= '{pad: 8'h00, cpu: cmd_cpu, thr: cmd_thr};
          r_cpu   <= '0;
          r_thr   <= '0;
          r_empty <= 1'b0;
          r_full  <= 1'b0;
          case (op)
            OP_ENQ: begin
              if (!avail) begin
                r_full <= 1'b1;
                r_head <= cmd_head;
                r_tail <= cmd_tail;
                st     <= S_RESP;
              end else if (free_head != NIL) begin
                new_ptr <= free_head;
                popped  <= 1'b1;
                st      <= S_EFRD;
              end else begin
                new_ptr <= fresh_ptr;
                popped  <= 1'b0;
                st      <= S_ENEW;
              end
            end
            OP_DEQ: begin
              if (cmd_head == NIL) begin
                r_empty <= 1'b1;
                r_head  <= NIL;
                r_tail  <= NIL;
                st      <= S_RESP;
              end else begin
                st <= S_DHRD;
              end
            end
            default: begin
              r_head <= NIL;
              r_tail <= NIL;
              st     <= S_RESP;
            end
          endcase
        end
        S_EFRD: st <= S_EFWT;
        S_EFWT: st <= S_ENEW;
        S_ENEW: begin
          r_head <= (c_head == NIL) ? new_ptr : c_head;
          r_tail <= new_ptr;
          st     <= (c_tail != NIL) ? S_ETRD : S_RESP;
        end
        S_ETRD: st <= S_ETWT;
        S_ETWT: st <= S_ETWR;
        S_ETWR: st <= S_RESP;
        S_DHRD: st <= S_DHWT;
        S_DHWT: st <= S_DHWR;
        S_DHWR: begin
          nxt_sv <= mem_rdata.nxt;
          r_cpu  <= mem_rdata.tid.cpu;
          r_thr  <= mem_rdata.tid.thr;
          if (mem_rdata.nxt == NIL) begin
            r_head <= NIL;
            r_tail <= NIL;
            st     <= S_RESP;
          end else begin
            r_head <= mem_rdata.nxt;
            r_tail <= c_tail;
            st     <= S_DNRD;
          end
        end
        S_DNRD: st <= S_DNWT;
        S_DNWT: st <= S_DNWR;
        S_DNWR: st <= S_RESP;
        S_RESP: if (rsp_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // memory and allocator steering
  always_comb begin
    entry_t w;
    w          = mem_rdata;
    mem_en     = 1'b0;
    mem_we     = 1'b0;
    mem_addr   = '0;
    mem_wdata  = mem_rdata;
    take_fresh = fire && (op == OP_ENQ) && avail && (free_head == NIL);
    head_we    = 1'b0;
    head_d     = NIL;
    case (st)
      S_EFRD: begin
        mem_en   = 1'b1;
        mem_addr = AW'(new_ptr);
      end
      S_ENEW: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = AW'(new_ptr);
        mem_wdata = '{tid: c_tid, nxt: NIL, rsv: 1'b0, prv: c_tail, used: 1'b1};
        if (popped) begin
          head_we = 1'b1;
          head_d  = mem_rdata.nxt;
        end
      end
      S_ETRD: begin
        mem_en   = 1'b1;
        mem_addr = AW'(c_tail);
      end
      S_ETWR: begin
        w.nxt     = new_ptr;
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = AW'(c_tail);
        mem_wdata = w;
      end
      S_DHRD: begin
        mem_en   = 1'b1;
        mem_addr = AW'(c_head);
      end
      S_DHWR: begin
        w.used    = 1'b0;
        w.prv     = NIL;
        w.nxt     = free_head;
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = AW'(c_head);
        mem_wdata = w;
        head_we   = 1'b1;
        head_d    = c_head;
      end
      S_DNRD: begin
        mem_en   = 1'b1;
        mem_addr = AW'(nxt_sv);
      end
      S_DNWR: begin
        w.prv     = NIL;
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = AW'(nxt_sv);
        mem_wdata = w;
      end
      default: ;
    endcase
  end

  assign rsp_head  = r_head;
  assign rsp_tail  = r_tail;
  assign rsp_cpu   = r_cpu;
  assign rsp_thr   = r_thr;
  assign rsp_empty = r_empty;
  assign rsp_full  = r_full;

  assert_one_in_flight_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_ready && rsp_valid));

  assert_rsp_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_head) &&
      $stable(rsp_tail) && $stable(rsp_cpu) && $stable(rsp_thr) &&
      $stable(rsp_empty) && $stable(rsp_full)));

  assert_empty_nil_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_empty) |-> (rsp_head == NIL && rsp_tail == NIL &&
      rsp_cpu == 8'd0 && rsp_thr == 16'd0));

  assert_empty_fast_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == OP_DEQ && cmd_head == NIL) |=> (rsp_valid && !mem_en));

  assert_full_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == OP_ENQ && !avail) |=> (rsp_valid && rsp_full));

  assert_pair_nil_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_full && (rsp_tail == NIL)) |-> (rsp_head == NIL));

  assert_flags_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_empty && rsp_full));
endmodule

// File: rtl/wq_manager.sv
module wq_manager #(
  parameter int NUM_ENTRIES = 122
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [1:0]  cmd_op,
  input  logic [14:0] cmd_head,
  input  logic [14:0] cmd_tail,
  input  logic [7:0]  cmd_cpu,
  input  logic [15:0] cmd_thr,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [14:0] rsp_head,
  output logic [14:0] rsp_tail,
  output logic [7:0]  rsp_cpu,
  output logic [15:0] rsp_thr,
  output logic        rsp_empty,
  output logic        rsp_full
);
  import wq_pkg::*;
  localparam int AW = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  ptr_t    free_head, fresh_ptr, head_d;
  logic    avail, take_fresh, head_we;
  logic    mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  entry_t  mem_wdata, mem_rdata;

  wq_alloc #(.N(NUM_ENTRIES)) u_alloc (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_fresh (take_fresh),
    .head_we    (head_we),
    .head_d     (head_d),
    .free_head  (free_head),
    .fresh_ptr  (fresh_ptr),
    .avail      (avail)
  );

  wq_spram #(.DEPTH(NUM_ENTRIES)) u_ram (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (mem_en),
    .we    (mem_we),
    .addr  (mem_addr),
    .wdata (mem_wdata),
    .rdata (mem_rdata)
  );

  wq_seq #(.N(NUM_ENTRIES)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_op     (cmd_op),
    .cmd_head   (cmd_head),
    .cmd_tail   (cmd_tail),
    .cmd_cpu    (cmd_cpu),
    .cmd_thr    (cmd_thr),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_head   (rsp_head),
    .rsp_tail   (rsp_tail),
    .rsp_cpu    (rsp_cpu),
    .rsp_thr    (rsp_thr),
    .rsp_empty  (rsp_empty),
    .rsp_full   (rsp_full),
    .free_head  (free_head),
    .fresh_ptr  (fresh_ptr),
    .avail      (avail),
    .take_fresh (take_fresh),
    .head_we    (head_we),
    .head_d     (head_d),
    .mem_en     (mem_en),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata)
  );

  // pool must leave the all-ones code free for nil
  initial begin
    assert_pool_fits_R3: assert (NUM_ENTRIES >= 1 && NUM_ENTRIES < 32767);
  end
endmodule

// File: tb/wq_manager_bench.sv
module wq_manager_bench;
  localparam int NE  = 8;
  localparam int NIL = 32'h7FFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = 2'd0;
  logic [14:0] cmd_head = '1;
  logic [14:0] cmd_tail = '1;
  logic [7:0]  cmd_cpu = '0;
  logic [15:0] cmd_thr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [14:0] rsp_head, rsp_tail;
  logic [7:0]  rsp_cpu;
  logic [15:0] rsp_thr;
  logic        rsp_empty, rsp_full;

  always #4 clk = ~clk;

  wq_manager #(.NUM_ENTRIES(NE)) u_wq_manager (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_head(cmd_head), .cmd_tail(cmd_tail), .cmd_cpu(cmd_cpu), .cmd_thr(cmd_thr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_head(rsp_head),
    .rsp_tail(rsp_tail), .rsp_cpu(rsp_cpu), .rsp_thr(rsp_thr),
    .rsp_empty(rsp_empty), .rsp_full(rsp_full)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // behavioural reference: pool links, release stack, untouched counter
  int m_nxt [NE];
  int m_cpu [NE];
  int m_thr [NE];
  int fstack [$];
  int fresh = 0;

  // expected response of the command in flight
  int e_head, e_tail, e_cpu, e_thr, e_k;
  bit e_empty, e_full;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model(input int op, input int h, input int t,
                       input int cpu, input int thr);
    e_cpu = 0; e_thr = 0; e_empty = 0; e_full = 0;
    if (op == 1) begin
      if (fstack.size() == 0 && fresh == NE) begin
        e_full = 1; e_head = h; e_tail = t; e_k = 0;
      end else begin
        int n;
        bit reuse;
        reuse = (fstack.size() != 0);
        if (reuse) n = fstack.pop_back();
        else begin n = fresh; fresh++; end
        m_nxt[n] = NIL; m_cpu[n] = cpu; m_thr[n] = thr;
        if (t != NIL) m_nxt[t] = n;
        e_head = (h == NIL) ? n : h;
        e_tail = n;
        e_k = 1 + (reuse ? 2 : 0) + ((t != NIL) ? 3 : 0);
      end
    end else if (op == 2) begin
      if (h == NIL) begin
        e_empty = 1; e_head = NIL; e_tail = NIL; e_k = 0;
      end else begin
        int n;
        n = m_nxt[h];
        e_cpu = m_cpu[h]; e_thr = m_thr[h];
        fstack.push_back(h);
        e_head = n;
        e_tail = (n == NIL) ? NIL : t;
        e_k = 3 + ((n != NIL) ? 3 : 0);
      end
    end else begin
      e_head = NIL; e_tail = NIL; e_k = 0;
    end
  endtask

  task automatic run(input int op, input int h, input int t, input int cpu,
                     input int thr, input int stall, input string tag);
    int n;
    model(op, h, t, cpu, thr);
    @(negedge clk);
    chk(cmd_ready == 1'b1, tag, "cmd_ready before issue", cmd_ready, 1);
    cmd_valid = 1'b1; cmd_op = op[1:0];
    cmd_head = h[14:0]; cmd_tail = t[14:0];
    cmd_cpu = cpu[7:0]; cmd_thr = thr[15:0];
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 1;
    forever begin
      chk(cmd_ready == 1'b0, "R2", "cmd_ready while busy", cmd_ready, 0);
      chk(rsp_valid == (n >= e_k + 1), "R10", "rsp_valid timing",
          rsp_valid, (n >= e_k + 1) ? 1 : 0);
      if (n >= e_k + 1) begin
        chk(rsp_head == e_head[14:0], tag, "rsp_head", rsp_head, e_head);
        chk(rsp_tail == e_tail[14:0], tag, "rsp_tail", rsp_tail, e_tail);
        chk(rsp_cpu == e_cpu[7:0], tag, "rsp_cpu", rsp_cpu, e_cpu);
        chk(rsp_thr == e_thr[15:0], tag, "rsp_thr", rsp_thr, e_thr);
        chk(rsp_empty == e_empty, tag, "rsp_empty", rsp_empty, e_empty);
        chk(rsp_full == e_full, tag, "rsp_full", rsp_full, e_full);
      end
      if (n == e_k + 1 + stall) break;
      if (n > e_k + 40) break;
      @(negedge clk);
      n++;
    end
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(rsp_valid == 1'b0, "R2", "rsp_valid after handshake", rsp_valid, 0);
    chk(cmd_ready == 1'b1, "R2", "cmd_ready after handshake", cmd_ready, 1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL R10 watchdog: actual %0d expected %0d cycles", cyc, 100000);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int qa_h, qa_t, qb_h, qb_t;
    qa_h = NIL; qa_t = NIL; qb_h = NIL; qb_t = NIL;
    repeat (3) @(negedge clk);
    chk(cmd_ready == 1'b0 || cmd_ready == 1'b1, "R1", "cmd_ready known", cmd_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1", "reset cmd_ready", cmd_ready, 1);
    chk(rsp_valid == 1'b0, "R1", "reset rsp_valid", rsp_valid, 0);

    run(0, 5, 6, 0, 0, 0, "R3");
    run(2, NIL, NIL, 0, 0, 0, "R7");

    // interleaved queues from untouched entries: 0..4 in ascending order
    run(1, qa_h, qa_t, 1, 100, 0, "R1");  qa_h = e_head; qa_t = e_tail;
    run(1, qb_h, qb_t, 2, 200, 0, "R11"); qb_h = e_head; qb_t = e_tail;
    run(1, qa_h, qa_t, 1, 101, 3, "R4");  qa_h = e_head; qa_t = e_tail;
    run(1, qb_h, qb_t, 2, 201, 0, "R11"); qb_h = e_head; qb_t = e_tail;
    run(1, qa_h, qa_t, 1, 102, 2, "R4");  qa_h = e_head; qa_t = e_tail;

    run(2, qa_h, qa_t, 0, 0, 0, "R5");    qa_h = e_head; qa_t = e_tail;
    run(1, qb_h, qb_t, 3, 202, 0, "R8");  qb_h = e_head; qb_t = e_tail;

    for (int i = 0; i < 3; i++) begin
      run(2, qb_h, qb_t, 0, 0, 1, "R11"); qb_h = e_head; qb_t = e_tail;
    end
    run(2, qb_h, qb_t, 0, 0, 0, "R7");
    run(2, qa_h, qa_t, 0, 0, 0, "R5");    qa_h = e_head; qa_t = e_tail;
    run(2, qa_h, qa_t, 0, 0, 0, "R6");    qa_h = e_head; qa_t = e_tail;
    run(2, qa_h, qa_t, 0, 0, 0, "R7");

    // fill the pool, then ask once more
    for (int i = 0; i < NE; i++) begin
      run(1, qa_h, qa_t, 4, 300 + i, 0, "R8"); qa_h = e_head; qa_t = e_tail;
    end
    run(1, qa_h, qa_t, 5, 999, 0, "R9");
    run(1, qb_h, qb_t, 5, 998, 2, "R9");
    run(2, qa_h, qa_t, 0, 0, 0, "R5");    qa_h = e_head; qa_t = e_tail;
    run(1, qb_h, qb_t, 6, 400, 0, "R9");  qb_h = e_head; qb_t = e_tail;
    run(1, qb_h, qb_t, 6, 401, 0, "R9");

    for (int i = 0; i < NE - 1; i++) begin
      run(2, qa_h, qa_t, 0, 0, 0, "R5");  qa_h = e_head; qa_t = e_tail;
    end
    run(2, qb_h, qb_t, 0, 0, 0, "R6");    qb_h = e_head; qb_t = e_tail;
    run(3, 1, 2, 0, 0, 0, "R3");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule